// File: doc/BRIEF.md
# Enable-Driven Channel Unpacker

This block takes a dense, sample-interleaved stream from a single show-ahead FIFO source and distributes it over `NUM_CH` converter channels. Only channels whose enable input is set receive samples, and no padding slots are reserved for disabled channels. Each time the sink requests data, the block takes exactly as many samples as the enabled channels consume: the enabled-channel count times the samples per channel (`CH_W / SMP_W`). It reads a new source word only when the leftover samples kept from earlier words cannot cover that amount.

A controller with three states sequences the work. In `IDLE` the transfer-active input is low, and all requests are ignored. The latched enable set follows the enable inputs, the residue is empty, and the stream-start flag is armed. In `RUN` requests are served. `FLUSH` lasts one cycle: it drops the residue and latches a new enable set.

The transitions are:
- `T_START`: `IDLE`→`RUN` when transfer-active is high.
- `T_STOP`: `RUN`→`IDLE`, or `FLUSH`→`IDLE`, when transfer-active is low.
- `T_RECONF`: `RUN`→`FLUSH` when the enable inputs differ from the latched set.
- `T_RESUME`: `FLUSH`→`RUN` when transfer-active is high.

A transfer-request output repeats the transfer-active input one cycle later. A sync output marks the first source read of each new stream.

Top module: `chan_unpack`

## Requirements
- R1: While reset is held, `src_rd`, `src_sync`, `xfer_out` and every `out_vld` bit are low and `snk_data` is all zero.
- R2: A request exists in a cycle when `snk_vld[k]` is high for at least one channel k whose latched enable is set. Valid bits on disabled channels alone cause no read and no output valid.
- R3: In a served request cycle, `src_rd` is high in that same cycle exactly when the residue holds fewer samples than required, and `src_data` is consumed at that clock edge. Example: with 4 channels of 32 bits, 16-bit samples and 3 channels enabled, 8 back-to-back requests cause 6 reads.
- R4: The samples of one request, taken in stream order, go to enabled channels in a fixed pattern. Sample n goes to the enabled channel of rank n mod E (ranks counted upward from channel 0) and fills slot n div E. Slot j sits at bits `[j*SMP_W +: SMP_W]` of the channel word. Source-word sample i sits at bits `[i*SMP_W +: SMP_W]`, and residue samples come before the new word.
- R5: `out_vld[k]` is high in the cycle after a served request, for each enabled channel only. The new data appears on `snk_data` in that same cycle and is held until the next served request.
- R6: The data of a disabled channel reads zero.
- R7: While transfer-active is low, no source read and no output valid occur. Any residue is discarded.
- R8: A change of the enable set passes through `FLUSH`. There the residue is discarded, and the first data afterwards comes from the next unread source word.
- R9: `xfer_out` equals `xfer_in` delayed by one clock.
- R10: `src_sync` is high together with the first `src_rd` after leaving `IDLE` or `FLUSH`, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock, the only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_in | input | 1 | Transfer active on the source side |
| xfer_out | output | 1 | Transfer request forwarded to the sink |
| src_rd | output | 1 | Source read; the current word is taken at this edge |
| src_data | input | NUM_CH*CH_W | Show-ahead source word of interleaved samples |
| src_sync | output | 1 | Marks the first read of a stream |
| snk_en | input | NUM_CH | Per-channel enable |
| snk_vld | input | NUM_CH | Per-channel request from the sink |
| snk_data | output | NUM_CH*CH_W | Channel k at bits [k*CH_W +: CH_W] |
| out_vld | output | NUM_CH | Delayed per-channel data valid |

## Verification
The hardest situation to reach is an enable change, or a transfer drop, while the residue holds a partial word. After it, the next sample must come from a fresh word and not from the discarded leftovers. The stimulus walks through all sixteen enable sets of a 4-channel build in sequence, issuing random bursts of requests between changes. This leaves residues of varying depth at each reconfiguration. A directed transfer drop is made mid-stream. Random valid masks often hit only disabled channels, which exercises the request rule.

// File: rtl/upk_pkg.sv
package upk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } upk_state_e;
endpackage

// File: rtl/upk_fsm.sv
module upk_fsm
    import upk_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_in,
    input  logic [NUM_CH-1:0] en_in,
    input  logic              rd_seen,
    output logic [NUM_CH-1:0] en_q,
    output logic              serve_ok,
    output logic              clr,
    output logic              fresh,
    output logic              xfer_out
);
    upk_state_e state_q, state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (xfer_in) state_d = ST_RUN;
            ST_RUN: begin
                if (!xfer_in)          state_d = ST_IDLE;
                else if (en_in != en_q) state_d = ST_FLUSH;
            end
            ST_FLUSH: state_d = xfer_in ? ST_RUN : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            fresh    <= 1'b1;
            xfer_out <= 1'b0;
        end else begin
            xfer_out <= xfer_in;
            if (state_q != ST_RUN) begin
                en_q  <= en_in;
                fresh <= 1'b1;
            end else if (rd_seen) begin
                fresh <= 1'b0;
            end
        end
    end

    always_comb begin
        clr      = (state_q != ST_RUN);
        serve_ok = (state_q == ST_RUN) && xfer_in && (en_in == en_q);
    end

    // R8
    flush_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FLUSH |=> state_q != ST_FLUSH);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_in |=> state_q != ST_RUN);
endmodule

// File: rtl/upk_store.sv
module upk_store #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 32,
    parameter int SMP_W  = 16,
    localparam int WS    = NUM_CH * CH_W / SMP_W,
    localparam int BUF   = 2 * WS,
    localparam int CW    = $clog2(BUF + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   fire,
    input  logic [CW-1:0]          need,
    input  logic [WS*SMP_W-1:0]    src_word,
    output logic                   rd,
    output logic [BUF*SMP_W-1:0]   pool
);
    localparam int WB = WS * SMP_W;
    localparam int BB = BUF * SMP_W;

    logic [BB-1:0] buf_q;
    logic [BB-1:0] word_ext;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] total;

    assign rd = fire && (cnt_q < need);

    always_comb begin
        word_ext = {{(BB-WB){1'b0}}, src_word};
        pool     = buf_q;
        if (rd) pool = buf_q | (word_ext << (cnt_q * SMP_W));
        total = cnt_q + (rd ? CW'(WS) : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            buf_q <= '0;
            cnt_q <= '0;
        end else if (fire) begin
            buf_q <= pool >> (need * SMP_W);
            cnt_q <= total - need;
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(BUF));

    // R3
    residue_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> cnt_q < CW'(WS));
endmodule

// File: rtl/upk_route.sv
module upk_route #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 32,
    parameter int SMP_W  = 16,
    localparam int SPC   = CH_W / SMP_W,
    localparam int BUF   = 2 * NUM_CH * SPC,
    localparam int EW    = $clog2(NUM_CH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fire,
    input  logic [NUM_CH-1:0]       en,
    input  logic [EW-1:0]           ecount,
    input  logic [BUF*SMP_W-1:0]    pool,
    output logic [NUM_CH*CH_W-1:0]  data_q,
    output logic [NUM_CH-1:0]       vld_q
);
    logic [EW-1:0]   rank [NUM_CH];
    logic [CH_W-1:0] sel  [NUM_CH];

    always_comb begin
        logic [EW-1:0] acc;
        acc = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            rank[k] = acc;
            acc     = acc + EW'(en[k]);
        end
        for (int k = 0; k < NUM_CH; k++) begin
            for (int j = 0; j < SPC; j++) begin
                int idx;
                idx = j * int'(ecount) + int'(rank[k]);
                sel[k][j*SMP_W +: SMP_W] = pool[idx*SMP_W +: SMP_W];
            end
        end
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[k*CH_W +: CH_W] <= '0;
                vld_q[k]               <= 1'b0;
            end else begin
                vld_q[k] <= fire && en[k];
                if (!en[k])    data_q[k*CH_W +: CH_W] <= '0;
                else if (fire) data_q[k*CH_W +: CH_W] <= sel[k];
            end
        end

        // R6
        lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[k] && $past(!en[k])) |-> data_q[k*CH_W +: CH_W] == '0);
    end
endmodule

// File: rtl/chan_unpack.sv
module chan_unpack #(
    parameter int CH_W   = 32,
    parameter int NUM_CH = 8,
    parameter int SMP_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   xfer_in,
    output logic                   xfer_out,
    output logic                   src_rd,
    input  logic [NUM_CH*CH_W-1:0] src_data,
    output logic                   src_sync,
    input  logic [NUM_CH-1:0]      snk_en,
    input  logic [NUM_CH-1:0]      snk_vld,
    output logic [NUM_CH*CH_W-1:0] snk_data,
    output logic [NUM_CH-1:0]      out_vld
);
    localparam int SPC = CH_W / SMP_W;
    localparam int WS  = NUM_CH * SPC;
    localparam int BUF = 2 * WS;
    localparam int CW  = $clog2(BUF + 1);
    localparam int EW  = $clog2(NUM_CH + 1);

    logic [NUM_CH-1:0]    en_q;
    logic                 serve_ok, clr, fresh, fire;
    logic [EW-1:0]        ecount;
    logic [CW-1:0]        need;
    logic [BUF*SMP_W-1:0] pool;

    always_comb begin
        ecount = '0;
        for (int k = 0; k < NUM_CH; k++) ecount = ecount + EW'(en_q[k]);
    end

    assign need     = CW'(int'(ecount) * SPC);
    assign fire     = serve_ok && (|(snk_vld & en_q)) && (ecount != '0);
    assign src_sync = src_rd && fresh;

    upk_fsm #(.NUM_CH(NUM_CH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .xfer_in(xfer_in), .en_in(snk_en),
        .rd_seen(src_rd), .en_q(en_q), .serve_ok(serve_ok), .clr(clr),
        .fresh(fresh), .xfer_out(xfer_out)
    );

    upk_store #(.NUM_CH(NUM_CH), .CH_W(CH_W), .SMP_W(SMP_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .fire(fire), .need(need),
        .src_word(src_data), .rd(src_rd), .pool(pool)
    );

    upk_route #(.NUM_CH(NUM_CH), .CH_W(CH_W), .SMP_W(SMP_W)) u_route (
        .clk(clk), .rst_n(rst_n), .fire(fire), .en(en_q), .ecount(ecount),
        .pool(pool), .data_q(snk_data), .vld_q(out_vld)
    );

    // R7
    no_read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_in |-> !src_rd);

    // R5
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_vld) |-> $past(|(snk_vld & snk_en)));

    // R10
    sync_with_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_sync |-> src_rd);

    // R9
    xfer_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_out) |-> $past(xfer_in));
endmodule

// File: tb/chan_unpack_bench.sv
module chan_unpack_bench;
    localparam int NCH = 4;
    localparam int CHW = 32;
    localparam int SW  = 16;
    localparam int SPC = CHW / SW;
    localparam int WS  = NCH * SPC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic                xfer_in, xfer_out, src_rd, src_sync;
    logic [NCH*CHW-1:0]  src_data, snk_data;
    logic [NCH-1:0]      snk_en, snk_vld, out_vld;

    chan_unpack #(.CH_W(CHW), .NUM_CH(NCH), .SMP_W(SW)) u_chan_unpack (
        .clk(clk), .rst_n(rst_n), .xfer_in(xfer_in), .xfer_out(xfer_out),
        .src_rd(src_rd), .src_data(src_data), .src_sync(src_sync),
        .snk_en(snk_en), .snk_vld(snk_vld), .snk_data(snk_data), .out_vld(out_vld)
    );

    int checks = 0, errors = 0;
    int wi = 0, p = 0, rd_total = 0;
    bit fresh_m = 1'b1, run_m = 1'b0;
    logic [NCH-1:0] en_cur = '0;

    function automatic logic [SW-1:0] samp(int n);
        return SW'(n * 40503 + 7 + (n >>> 5));
    endfunction

    function automatic logic [NCH*CHW-1:0] word(int w);
        logic [NCH*CHW-1:0] r;
        for (int i = 0; i < WS; i++) r[i*SW +: SW] = samp(w * WS + i);
        return r;
    endfunction

    function automatic int pc(logic [NCH-1:0] v);
        int c = 0;
        for (int i = 0; i < NCH; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(logic [NCH-1:0] vld);
        int e, need, rk;
        bit fire_m, exp_rd;
        logic [CHW-1:0] expd [NCH];
        @(negedge clk);
        snk_vld = vld;
        #1;
        e      = pc(en_cur);
        need   = e * SPC;
        fire_m = run_m && (|(vld & en_cur)) && (e != 0);
        exp_rd = fire_m && ((wi * WS - p) < need);
        chk(src_rd == exp_rd, "R3 read request", 64'(src_rd), 64'(exp_rd));
        chk(src_sync == (exp_rd && fresh_m), "R10 sync", 64'(src_sync), 64'(exp_rd && fresh_m));
        rk = 0;
        for (int k = 0; k < NCH; k++) begin
            expd[k] = '0;
            if (en_cur[k]) begin
                for (int j = 0; j < SPC; j++) expd[k][j*SW +: SW] = samp(p + j * e + rk);
                rk++;
            end
        end
        @(posedge clk);
        #1;
        if (exp_rd) begin
            wi++;
            rd_total++;
            fresh_m  = 1'b0;
            src_data = word(wi);
        end
        if (fire_m) p += need;
        chk(out_vld == (fire_m ? en_cur : '0), "R5 output valid (R2 request rule)",
            64'(out_vld), 64'(fire_m ? en_cur : '0));
        for (int k = 0; k < NCH; k++) begin
            if (fire_m && en_cur[k])
                chk(snk_data[k*CHW +: CHW] == expd[k], "R4 sample routing",
                    64'(snk_data[k*CHW +: CHW]), 64'(expd[k]));
            else if (!en_cur[k])
                chk(snk_data[k*CHW +: CHW] == '0, "R6 disabled zero",
                    64'(snk_data[k*CHW +: CHW]), 64'd0);
        end
    endtask

    // R8: enable change with the residue dropped
    task automatic reconf(logic [NCH-1:0] ne);
        @(negedge clk);
        snk_vld = '0;
        snk_en  = ne;
        repeat (4) @(negedge clk);
        if (ne != en_cur) begin
            p       = wi * WS;
            fresh_m = 1'b1;
        end
        en_cur = ne;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'd4242));
        xfer_in  = 1'b0;
        snk_en   = '0;
        snk_vld  = '0;
        src_data = word(0);
        repeat (3) @(negedge clk);
        // R1
        chk(src_rd == 1'b0, "R1 reset read", 64'(src_rd), 64'd0);
        chk(out_vld == '0, "R1 reset valid", 64'(out_vld), 64'd0);
        chk(snk_data == '0, "R1 reset data", 64'(snk_data[63:0]), 64'd0);
        chk(xfer_out == 1'b0, "R1 reset xfer", 64'(xfer_out), 64'd0);
        chk(src_sync == 1'b0, "R1 reset sync", 64'(src_sync), 64'd0);
        rst_n = 1'b1;

        // R7: requests while transfer-active is low
        reconf(4'b1111);
        repeat (3) tick(4'b1111);

        // R9: forwarding delay
        @(negedge clk);
        xfer_in = 1'b1;
        #1 chk(xfer_out == 1'b0, "R9 xfer delay", 64'(xfer_out), 64'd0);
        @(posedge clk);
        #1 chk(xfer_out == 1'b1, "R9 xfer follow", 64'(xfer_out), 64'd1);
        run_m = 1'b1;

        // R3: duty cycle with 3 of 4 channels
        reconf(4'b0111);
        base = rd_total;
        repeat (8) tick(4'b0111);
        chk(rd_total - base == 6, "R3 read duty", 64'(rd_total - base), 64'd6);

        // every enable set, random requests
        for (int c = 0; c < 16; c++) begin
            reconf(NCH'(c));
            for (int n = 0; n < 20; n++) begin
                int unsigned r = $urandom();
                tick((r % 4 != 0) ? NCH'(r >> 4) : '0);
            end
        end

        // R7: transfer drop with a partial residue
        reconf(4'b1011);
        repeat (3) tick(4'b1011);
        @(negedge clk);
        xfer_in = 1'b0;
        run_m   = 1'b0;
        repeat (3) tick(4'b1111);
        chk(xfer_out == 1'b0, "R9 xfer drop", 64'(xfer_out), 64'd0);
        p       = wi * WS;
        fresh_m = 1'b1;
        @(negedge clk);
        xfer_in = 1'b1;
        @(posedge clk);
        run_m = 1'b1;
        repeat (10) tick(4'b1011);

        summary();
        $finish;
    end
endmodule